// File: doc/BRIEF.md
# Reaction Time Meter

This block measures how quickly a person reacts to a visual cue. After a start press it waits a pseudorandom interval and then lights a stimulus LED. From that moment it counts elapsed milliseconds until a stop press arrives. It then shows the frozen count on a four-digit multiplexed seven-segment display as seconds with three decimals (d.ddd). A clear press returns it to idle with the display at 0.000.

The three control inputs are single-cycle pulses that are already debounced. A prescaler makes a one-cycle millisecond tick, and its divide ratio is a parameter. A free-running 16-bit maximal-length LFSR supplies the random part of the wait. That wait is MIN_DELAY_MS plus the low RAND_BITS bits of the LFSR, counted in ticks; the defaults give roughly 1 s to 3 s. The elapsed time is kept as four cascaded BCD digits and saturates at 9.999 s.

A stop press during the wait is a false start. The LED stays off and the display reads 9.999 until clear.

Top module: `reaction_timer`

## Requirements
- R1: After reset the LED is off and the display reads 0000 (the decimal point appears only on the most significant digit).
- R2: A start press in idle lights the LED after D ticks, where D is MIN_DELAY_MS plus a pseudorandom value in 0 to 2^RAND_BITS-1.
- R3: While the LED is on, the count rises by one on every millisecond tick. A stop press turns the LED off and freezes the count, and the display then shows the number of ticks that elapsed between the LED turning on and the stop.
- R4: The count is held as four BCD digits. Each digit wraps from 9 to 0 and carries into the next more significant digit.
- R5: The count saturates at 9999 and never wraps to 0000.
- R6: A stop press during the random wait is a false start. The LED never lights and the display reads 9999 until clear.
- R7: A clear press in any state returns the block to idle, turns the LED off and sets the display to 0000. Clear takes priority over a start or stop press in the same cycle.
- R8: A start press outside idle is ignored. It does not relight the LED and does not change the displayed value.
- R9: Exactly one active-low anode is driven at a time, and the scan runs through digit 0 (least significant) up to digit 3, moving to the next digit every SCAN_DIV cycles. Segments are active low, with bit 0 as segment a through bit 6 as segment g. The active-low decimal point is on only while anode 3 is selected.
- R10: The LED is lit only during the timing phase, which runs from the end of the random wait until stop or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Clear pulse, one cycle |
| start_i | input | 1 | Start pulse, one cycle |
| stop_i | input | 1 | Stop pulse, one cycle |
| led_o | output | 1 | Stimulus LED, active high |
| anode_o | output | 4 | Digit enables, active low; bit 3 is the most significant digit |
| seg_o | output | 7 | Segments a..g on bits 0..6, active low |
| dp_o | output | 1 | Decimal point, active low |

## Verification
Some properties are checked on every cycle. Exactly one anode is active, and the decimal point is tied to the top digit. The count can change only while timing, and a saturated count holds at 9999. Clear, a false-start stop and a start press during timing each lead to the expected next state. The LED can only come on at the end of the wait.

Other behaviour can only be shown by the bench scenarios. These are the exact tick count after a given run length and the BCD carries at 9, 99 and 999. They also cover the window in which the pseudorandom delay must fall, the 9.999 shown after a false start, and the digit-by-digit decoding of the multiplexed display.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int LFSR_W     = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_DONE,
    ST_FALSE
  } rt_state_e;

  // active-high pattern, bit0 = a .. bit6 = g
  function automatic logic [6:0] seg_encode(input logic [3:0] d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h40;
    endcase
  endfunction
endpackage

// File: rtl/rt_tick.sv
module rt_tick #(
  parameter int DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rt_lfsr.sv
module rt_lfsr
  import rt_pkg::*;
#(
  parameter int               OUT_W = 11,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  // x^16 + x^14 + x^13 + x^11 + 1, maximal length
  assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  assign rnd_o = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/rt_bcd_counter.sv
module rt_bcd_counter #(
  parameter int DIGITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                inc_i,
  output logic [4*DIGITS-1:0] bcd_o
);
  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] is_nine;
  logic              sat;

  assign sat      = &is_nine;
  assign carry[0] = inc_i & ~sat;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig_q;
    assign is_nine[g]    = (dig_q == 4'd9);
    assign carry[g+1]    = carry[g] & is_nine[g];
    assign bcd_o[4*g +: 4] = dig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= 4'd0;
      else if (clr_i)    dig_q <= 4'd0;
      else if (carry[g]) dig_q <= is_nine[g] ? 4'd0 : dig_q + 4'd1;
    end
  end
endmodule

// File: rtl/rt_scan.sv
module rt_scan
  import rt_pkg::*;
#(
  parameter int DIGITS   = 4,
  parameter int SCAN_DIV = 50000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [4*DIGITS-1:0] bcd_i,
  output logic [DIGITS-1:0]   anode_o,
  output logic [6:0]          seg_o,
  output logic                dp_o
);
  localparam int CW    = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic [CW-1:0]    div_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sel_q <= '0;
    end else if (div_q == CW'(SCAN_DIV - 1)) begin
      div_q <= '0;
      sel_q <= (sel_q == SEL_W'(DIGITS - 1)) ? '0 : sel_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_anode
    assign anode_o[g] = (sel_q != SEL_W'(g));
  end

  assign seg_o = ~seg_encode(bcd_i[4*sel_q +: 4]);
  assign dp_o  = (sel_q != SEL_W'(DIGITS - 1));
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int TICK_DIV     = 50000,
  parameter int MIN_DELAY_MS = 1000,
  parameter int RAND_BITS    = 11,
  parameter int SCAN_DIV     = 50000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  output logic                  led_o,
  output logic [NUM_DIGITS-1:0] anode_o,
  output logic [6:0]            seg_o,
  output logic                  dp_o
);
  localparam int DLY_MAX = MIN_DELAY_MS + (1 << RAND_BITS) - 1;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);

  rt_state_e                   state_q, state_d;
  logic [DLY_W-1:0]            dly_q;
  logic [RAND_BITS-1:0]        rnd;
  logic                        tick;
  logic [4*NUM_DIGITS-1:0]     bcd, disp_bcd;

  rt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  rt_lfsr #(.OUT_W(RAND_BITS)) u_lfsr (
    .clk_i, .rst_ni, .rnd_o(rnd)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (stop_i)                           state_d = ST_FALSE;
        else if (tick && dly_q == DLY_W'(1))  state_d = ST_RUN;
      end
      ST_RUN:  if (stop_i) state_d = ST_DONE;
      default: ;
    endcase
    if (clear_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i)
        dly_q <= DLY_W'(MIN_DELAY_MS) + DLY_W'(rnd);
      else if (state_q == ST_WAIT && tick && dly_q != '0)
        dly_q <= dly_q - 1'b1;
    end
  end

  rt_bcd_counter #(.DIGITS(NUM_DIGITS)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(clear_i),
    .inc_i((state_q == ST_RUN) && tick),
    .bcd_o(bcd)
  );

  // false start forces the all-nines readout
  assign disp_bcd = (state_q == ST_FALSE) ? {NUM_DIGITS{4'd9}} : bcd;

  rt_scan #(.DIGITS(NUM_DIGITS), .SCAN_DIV(SCAN_DIV)) u_scan (
    .clk_i, .rst_ni,
    .bcd_i(disp_bcd),
    .anode_o, .seg_o, .dp_o
  );

  assign led_o = (state_q == ST_RUN);
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clear_i,
  input logic                    start_i,
  input logic                    stop_i,
  input logic                    led_o,
  input logic [NUM_DIGITS-1:0]   anode_o,
  input logic                    dp_o,
  input rt_state_e               state_i,
  input logic [4*NUM_DIGITS-1:0] bcd_i
);
  a_r9_one_anode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~anode_o) == 1);

  a_r9_dp_msd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_o == anode_o[NUM_DIGITS-1]);

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_RUN && !clear_i) |=> $stable(bcd_i));

  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcd_i == {NUM_DIGITS{4'd9}} && !clear_i) |=> bcd_i == {NUM_DIGITS{4'd9}});

  a_r6_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && stop_i && !clear_i) |=> (state_i == ST_FALSE && !led_o));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_i == ST_IDLE && bcd_i == '0 && !led_o));

  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && start_i && !stop_i && !clear_i) |=> state_i == ST_RUN);

  a_r10_led_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(led_o) |-> $past(state_i) == ST_WAIT);
endmodule

bind reaction_timer rt_checker u_chk (
  .clk_i, .rst_ni, .clear_i, .start_i, .stop_i,
  .led_o, .anode_o, .dp_o,
  .state_i(state_q),
  .bcd_i(bcd)
);

// File: tb/reaction_timer_tb.sv
module reaction_timer_tb;
  localparam int DIV  = 4;
  localparam int MIN  = 8;
  localparam int RB   = 4;
  localparam int SCAN = 3;
  localparam int NV   = 8;
  localparam int unsigned RUN_MS [NV] = '{0, 1, 9, 10, 99, 100, 999, 1234};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic       led_o, dp_o;
  logic [3:0] anode_o;
  logic [6:0] seg_o;

  always #4 clk = ~clk;

  reaction_timer #(
    .TICK_DIV(DIV), .MIN_DELAY_MS(MIN), .RAND_BITS(RB), .SCAN_DIV(SCAN)
  ) u_dut (
    .clk_i(clk), .rst_ni, .clear_i, .start_i, .stop_i,
    .led_o, .anode_o, .seg_o, .dp_o
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [3:0] seg2dig(input logic [6:0] s);
    case (~s)
      7'h3F: return 4'd0;  7'h06: return 4'd1;
      7'h5B: return 4'd2;  7'h4F: return 4'd3;
      7'h66: return 4'd4;  7'h6D: return 4'd5;
      7'h7D: return 4'd6;  7'h07: return 4'd7;
      7'h7F: return 4'd8;  7'h6F: return 4'd9;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [15:0] to_bcd(input int unsigned v);
    logic [15:0] r;
    for (int k = 0; k < 4; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press(input int which);
    @(negedge clk);
    case (which)
      0: clear_i = 1'b1;
      1: start_i = 1'b1;
      default: stop_i = 1'b1;
    endcase
    @(negedge clk);
    clear_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
  endtask

  // reads all four digits; dp_ok false if dp is wrong on any digit
  task automatic read_disp(output logic [15:0] val, output bit dp_ok);
    dp_ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      while (anode_o != ~(4'b1 << k)) @(negedge clk);
      val[4*k +: 4] = seg2dig(seg_o);
      if (dp_o != (k != 3)) dp_ok = 1'b0;
    end
  endtask

  // returns edges between start registration and LED on
  task automatic start_and_wait(output int d);
    int n = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!led_o) begin
      @(negedge clk);
      n++;
    end
    d = n - 1;
  endtask

  // after LED seen: let m ticks elapse, then stop
  task automatic run_ms(input int unsigned m);
    repeat (m * DIV) @(posedge clk);
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit          dpok;
    int          d;
    int          prev, cur, act;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(led_o == 1'b0, "R1 led", 32'(led_o), 0);
    read_disp(v, dpok);
    chk(v == 16'h0000, "R1 display", 32'(v), 0);
    chk(dpok, "R1 dp", 32'(dpok), 1);

    // vector table walk: R2 R3 R4 R8 R10 R7
    for (int i = 0; i < NV; i++) begin
      start_and_wait(d);
      chk(d >= (MIN - 1) * DIV + 1 && d <= (MIN + (1 << RB) - 1) * DIV,
          "R2 delay window", 32'(d), 32'(MIN * DIV));
      run_ms(RUN_MS[i]);
      chk(led_o == 1'b0, "R10 led off after stop", 32'(led_o), 0);
      read_disp(v, dpok);
      chk(v == to_bcd(RUN_MS[i]), "R3/R4 frozen count", 32'(v), 32'(to_bcd(RUN_MS[i])));
      chk(dpok, "R9 dp on msd", 32'(dpok), 1);
      press(1);
      repeat (20 * DIV) @(negedge clk);
      chk(led_o == 1'b0, "R8 start after stop", 32'(led_o), 0);
      read_disp(v, dpok);
      chk(v == to_bcd(RUN_MS[i]), "R8 display kept", 32'(v), 32'(to_bcd(RUN_MS[i])));
      press(0);
      chk(led_o == 1'b0, "R7 led", 32'(led_o), 0);
      read_disp(v, dpok);
      chk(v == 16'h0000, "R7 display cleared", 32'(v), 0);
    end

    // R9 scan order and single anode
    prev = -1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      act = 0; cur = 0;
      for (int k = 0; k < 4; k++) if (!anode_o[k]) begin act++; cur = k; end
      chk(act == 1, "R9 one anode", 32'(act), 1);
      if (prev >= 0 && cur != prev)
        chk(cur == (prev + 1) % 4, "R9 scan order", 32'(cur), 32'((prev + 1) % 4));
      prev = cur;
    end

    // R6 false start
    press(1);
    repeat (8) @(negedge clk);
    press(2);
    chk(led_o == 1'b0, "R6 led off", 32'(led_o), 0);
    read_disp(v, dpok);
    chk(v == 16'h9999, "R6 shows 9999", 32'(v), 32'h9999);
    repeat ((MIN + (1 << RB)) * DIV + 20) @(negedge clk);
    chk(led_o == 1'b0, "R6 led never lit", 32'(led_o), 0);
    press(1);
    repeat ((MIN + (1 << RB)) * DIV + 20) @(negedge clk);
    chk(led_o == 1'b0, "R8 start in false state", 32'(led_o), 0);
    press(0);
    read_disp(v, dpok);
    chk(v == 16'h0000, "R7 clear after false start", 32'(v), 0);

    // R8 start during timing
    start_and_wait(d);
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(led_o == 1'b1, "R8 start in run keeps led", 32'(led_o), 1);
    press(0);

    // R7 clear during run and during wait
    start_and_wait(d);
    run_ms(0);
    press(0);
    start_and_wait(d);
    repeat (30 * DIV) @(negedge clk);
    press(0);
    chk(led_o == 1'b0, "R7 clear in run led", 32'(led_o), 0);
    read_disp(v, dpok);
    chk(v == 16'h0000, "R7 clear in run display", 32'(v), 0);
    press(1);
    repeat (4) @(negedge clk);
    press(0);
    repeat ((MIN + (1 << RB)) * DIV + 20) @(negedge clk);
    chk(led_o == 1'b0, "R7 clear in wait", 32'(led_o), 0);

    // R5 saturation
    start_and_wait(d);
    run_ms(10003);
    read_disp(v, dpok);
    chk(v == 16'h9999, "R5 saturate", 32'(v), 32'h9999);
    press(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule